// File: doc/BRIEF.md
# PN Spread Correlator Bank

This block despreads the output of a pulse matched filter in a direct-sequence impulse receiver. Each pulse repetition period yields one chip. For that chip, the filter hands over one signed sample for every sample position of the receive window. The bank holds one correlator per window position. Each correlator adds or subtracts its sample according to the current spreading chip. At the programmed symbol boundary it dumps its running sum and starts again from zero.

The spreading chips come from an on-block code store with two independent tables, one for synchronisation and one for data. A chip address steps once per accepted chip and wraps at a programmable length of 1 to 1024 chips. A strobe-phase setting places the symbol boundary anywhere in the sequence. Correlators are grouped into blocks. A per-lane enable mask idles lanes that are not needed, and a block with no enabled lane takes no chip updates at all.

The code tables are loaded through a bit-wide write port while the bank is stopped. Starting the bank (`run_i` high) restarts the sequence at address 0 with every accumulator cleared.

Top module: `pn_corr_bank`

## Requirements
- R1: When a chip is accepted (`run_i` and `chip_valid_i` high at a clock edge), every enabled lane adds its signed two's complement sample if the code bit is 1 and subtracts it if the bit is 0. Lane l takes its sample from `samples_i[l*SAMPLE_W +: SAMPLE_W]`. Cycles with `chip_valid_i` low change no accumulator.
- R2: The code address is 0 on the first chip after `run_i` rises. It advances by one per accepted chip and returns to 0 after the chip at address `len_m1_i`, so the sequence length is `len_m1_i`+1 chips (1 to 1024).
- R3: The clock cycle after the edge that accepts the chip at address `phase_i` (`phase_i` ≤ `len_m1_i`), `sym_valid_o` is high for exactly one cycle. `sums_o` then holds each lane's sum including that chip, and accumulation restarts from zero with the next chip.
- R4: `sums_o` holds its value between strobes. Lane l occupies `sums_o[l*ACC_W +: ACC_W]`, signed.
- R5: `code_sel_i` = 0 reads chips from the synchronisation table and `code_sel_i` = 1 reads them from the data table.
- R6: A lane whose `lane_en_i` bit is 0 keeps its accumulator at zero and reports zero at each strobe.
- R7: A write (`wr_en_i` high) stores `wr_bit_i` at `wr_addr_i` of table `wr_sel_i` (0 = sync, 1 = data) only while `run_i` is low. While `run_i` is high, writes are ignored.
- R8: With `run_i` low, no chip is accepted, the address returns to 0 and all accumulators clear. A partial symbol is discarded.
- R9: The sum width is SAMPLE_W + log2(MAX_CHIPS) + 1. A 1024-chip symbol of full-scale negative samples under all-zero chips reports +1024·2^(SAMPLE_W-1) without wrap.
- R10: After reset, `sym_valid_o` is 0, `sums_o` is 0 and both code tables hold all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Bank running; low clears address and sums |
| chip_valid_i | input | 1 | One new chip of samples this cycle |
| samples_i | input | N_LANES*SAMPLE_W | Signed filtered samples, one per lane |
| lane_en_i | input | N_LANES | Per-lane enable |
| len_m1_i | input | AW | Sequence length minus one |
| phase_i | input | AW | Address of the last chip of a symbol |
| code_sel_i | input | 1 | Table used for reads: 0 sync, 1 data |
| wr_en_i | input | 1 | Code table write strobe |
| wr_sel_i | input | 1 | Table written: 0 sync, 1 data |
| wr_addr_i | input | AW | Code bit address |
| wr_bit_i | input | 1 | Code bit value |
| sym_valid_o | output | 1 | One-cycle strobe: new sums available |
| sums_o | output | N_LANES*ACC_W | Signed per-lane correlation sums |

## Verification
Random codes and random signed samples are run under a full-length boundary (phase at the last chip) and under a mid-sequence phase. The mid-sequence case separates a correct boundary position from one fixed to the wrap. A one-chip sequence exposes off-by-one errors in the wrap and the dump. Random gaps in `chip_valid_i` distinguish per-chip stepping from per-cycle stepping. Switching to the data table, random lane masks, a mid-symbol stop, a write issued while running to an address read later, and a 1024-chip full-scale symbol each isolate one of the remaining paths.

// File: rtl/pn_corr_pkg.sv
package pn_corr_pkg;
  // sample width + chip address bits + one guard bit for the negated minimum
  function automatic int acc_width(input int smp_w, input int addr_w);
    return smp_w + addr_w + 1;
  endfunction
endpackage

// File: rtl/pn_code_mem.sv
module pn_code_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  input  logic          rd_sel_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_bit_o
);
  logic [DEPTH-1:0] sync_q, data_q;
  logic             wr_ok;

  assign wr_ok = wr_en_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      if (wr_sel_i) data_q[wr_addr_i] <= wr_bit_i;
      else          sync_q[wr_addr_i] <= wr_bit_i;
    end
  end

  assign rd_bit_o = rd_sel_i ? data_q[rd_addr_i] : sync_q[rd_addr_i];

  assert_code_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(sync_q) && $stable(data_q)));
endmodule

// File: rtl/pn_addr_gen.sv
module pn_addr_gen #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          chip_valid_i,
  input  logic [AW-1:0] len_m1_i,
  input  logic [AW-1:0] phase_i,
  output logic [AW-1:0] addr_o,
  output logic          fire_o,
  output logic          dump_o
);
  logic [AW-1:0] addr_q;
  logic          at_end;

  assign at_end = (addr_q >= len_m1_i);
  assign fire_o = run_i && chip_valid_i;
  assign dump_o = fire_o && (addr_q == phase_i);
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (!run_i)    addr_q <= '0;
    else if (fire_o)    addr_q <= at_end ? '0 : addr_q + AW'(1);
  end

  assert_addr_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && addr_q == len_m1_i) |=> (addr_q == '0));
  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !chip_valid_i) |=> $stable(addr_q));
  assert_idle_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (addr_q == '0));
endmodule

// File: rtl/pn_corr_lane.sv
module pn_corr_lane #(
  parameter int SW    = 8,
  parameter int ACC_W = 19
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    en_i,
  input  logic                    fire_i,
  input  logic                    dump_i,
  input  logic                    chip_i,
  input  logic signed [SW-1:0]    smp_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [ACC_W-1:0] acc_q, sum_q, ext, term, acc_nx;

  assign ext    = {{(ACC_W-SW){smp_i[SW-1]}}, smp_i};
  assign term   = chip_i ? ext : -ext;
  assign acc_nx = acc_q + term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              acc_q <= '0;
    else if (!run_i || !en_i) acc_q <= '0;
    else if (fire_i)          acc_q <= dump_i ? '0 : acc_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sum_q <= '0;
    else if (fire_i && dump_i) sum_q <= en_i ? acc_nx : '0;
  end

  assign sum_o = sum_q;

  assert_lane_off_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));
  assert_lane_off_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && dump_i && !en_i) |=> (sum_o == '0));
  assert_sum_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && dump_i) |=> $stable(sum_o));
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && en_i && run_i && (acc_q[ACC_W-1] == term[ACC_W-1]))
      |=> ($past(dump_i) || acc_q[ACC_W-1] == $past(acc_q[ACC_W-1])));
endmodule

// File: rtl/pn_corr_block.sv
module pn_corr_block #(
  parameter int SW    = 8,
  parameter int ACC_W = 19,
  parameter int LANES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [LANES-1:0]       en_i,
  input  logic                   fire_i,
  input  logic                   dump_i,
  input  logic                   chip_i,
  input  logic [LANES*SW-1:0]    smp_i,
  output logic [LANES*ACC_W-1:0] sums_o
);
  logic blk_on, blk_fire;

  // whole block sits still when no lane in it is enabled
  assign blk_on   = |en_i;
  assign blk_fire = fire_i && blk_on;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACC_W-1:0] sum;
    pn_corr_lane #(.SW(SW), .ACC_W(ACC_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .en_i   (en_i[l]),
      .fire_i (blk_fire | (fire_i & dump_i)),
      .dump_i (dump_i),
      .chip_i (chip_i),
      .smp_i  (smp_i[l*SW +: SW]),
      .sum_o  (sum)
    );
    assign sums_o[l*ACC_W +: ACC_W] = sum;
  end
endmodule

// File: rtl/pn_corr_bank.sv
module pn_corr_bank
  import pn_corr_pkg::*;
#(
  parameter int N_LANES   = 16,
  parameter int BLK_LANES = 8,
  parameter int SAMPLE_W  = 8,
  parameter int MAX_CHIPS = 1024,
  parameter int AW        = $clog2(MAX_CHIPS),
  parameter int ACC_W     = acc_width(SAMPLE_W, AW)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic                       chip_valid_i,
  input  logic [N_LANES*SAMPLE_W-1:0] samples_i,
  input  logic [N_LANES-1:0]         lane_en_i,
  input  logic [AW-1:0]              len_m1_i,
  input  logic [AW-1:0]              phase_i,
  input  logic                       code_sel_i,
  input  logic                       wr_en_i,
  input  logic                       wr_sel_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic                       wr_bit_i,
  output logic                       sym_valid_o,
  output logic [N_LANES*ACC_W-1:0]   sums_o
);
  localparam int N_BLK = N_LANES / BLK_LANES;

  logic [AW-1:0] addr;
  logic          fire, dump, chip, sym_q;

  pn_addr_gen #(.AW(AW)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .chip_valid_i (chip_valid_i),
    .len_m1_i     (len_m1_i),
    .phase_i      (phase_i),
    .addr_o       (addr),
    .fire_o       (fire),
    .dump_o       (dump)
  );

  pn_code_mem #(.DEPTH(MAX_CHIPS), .AW(AW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (run_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_addr_i (wr_addr_i),
    .wr_bit_i  (wr_bit_i),
    .rd_sel_i  (code_sel_i),
    .rd_addr_i (addr),
    .rd_bit_o  (chip)
  );

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    pn_corr_block #(.SW(SAMPLE_W), .ACC_W(ACC_W), .LANES(BLK_LANES)) u_blk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .en_i   (lane_en_i[b*BLK_LANES +: BLK_LANES]),
      .fire_i (fire),
      .dump_i (dump),
      .chip_i (chip),
      .smp_i  (samples_i[b*BLK_LANES*SAMPLE_W +: BLK_LANES*SAMPLE_W]),
      .sums_o (sums_o[b*BLK_LANES*ACC_W +: BLK_LANES*ACC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sym_q <= 1'b0;
    else         sym_q <= dump;
  end
  assign sym_valid_o = sym_q;

  assert_strobe_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(run_i && chip_valid_i));
  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && len_m1_i != '0) |=> !sym_valid_o);
  initial assert (N_LANES % BLK_LANES == 0);
endmodule

// File: tb/pn_corr_bank_bench.sv
module pn_corr_bank_bench;
  localparam int NL = 16, SW = 8, MAXC = 1024, AW = 10, ACCW = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, cv = 0, csel = 0, wen = 0, wsel = 0, wbit = 0;
  logic [NL*SW-1:0] smp_v = '0;
  logic [NL-1:0] en = '1;
  logic [AW-1:0] len_m1 = '0, phase = '0, waddr = '0;
  logic sym;
  logic [NL*ACCW-1:0] sums;

  always #5 clk = ~clk;

  pn_corr_bank u_pn_corr_bank (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .chip_valid_i(cv),
    .samples_i(smp_v), .lane_en_i(en), .len_m1_i(len_m1), .phase_i(phase),
    .code_sel_i(csel), .wr_en_i(wen), .wr_sel_i(wsel), .wr_addr_i(waddr),
    .wr_bit_i(wbit), .sym_valid_o(sym), .sums_o(sums));

  int checks = 0, fails = 0;
  string req = "R10";
  bit code [2][MAXC];
  int smp [NL];
  longint acc [NL], exp_sum [NL];
  int baddr = 0;
  bit done = 0;

  function automatic longint lane_sum(input int l);
    return longint'($signed(sums[l*ACCW +: ACCW]));
  endfunction

  task automatic chk(input string r, input longint act, input longint ex);
    checks++;
    if (act != ex) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, ex);
    end
  endtask

  task automatic set_samples(input bit full_neg);
    for (int l = 0; l < NL; l++) begin
      smp[l] = full_neg ? -(1 << (SW-1)) : int'($urandom_range(0, 255)) - 128;
      smp_v[l*SW +: SW] = SW'(smp[l]);
    end
  endtask

  // one clock: model from held inputs, then compare after the edge
  task automatic step(input bit valid);
    bit strobe = 0;
    cv = valid;
    if (!run) begin
      baddr = 0;
      for (int l = 0; l < NL; l++) acc[l] = 0;
    end else if (valid) begin
      for (int l = 0; l < NL; l++)
        if (en[l]) acc[l] += code[csel][baddr] ? smp[l] : -smp[l];
      if (baddr == int'(phase)) begin
        strobe = 1;
        for (int l = 0; l < NL; l++) begin
          exp_sum[l] = en[l] ? acc[l] : 0;
          acc[l] = 0;
        end
      end
      baddr = (baddr >= int'(len_m1)) ? 0 : baddr + 1;
    end
    @(posedge clk); #1;
    cv = 0;
    chk({req, " strobe"}, longint'(sym), longint'(strobe));
    if (strobe || $urandom_range(0, 7) == 0)
      for (int l = 0; l < NL; l++) chk({req, " R4 sum"}, lane_sum(l), exp_sum[l]);
  endtask

  task automatic wr(input bit sel, input int a, input bit v);
    wen = 1; wsel = sel; waddr = AW'(a); wbit = v;
    @(posedge clk); #1;
    wen = 0;
  endtask

  task automatic run_chips(input int n, input bit gaps, input bit full_neg);
    for (int i = 0; i < n; i++) begin
      if (gaps && $urandom_range(0, 3) == 0) step(0);
      set_samples(full_neg);
      step(1);
    end
  endtask

  task automatic stop_bank();
    run = 0; step(0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 200000) begin @(posedge clk); wd++; end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int l = 0; l < NL; l++) begin acc[l] = 0; exp_sum[l] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 sym", longint'(sym), 0);
    for (int l = 0; l < NL; l++) chk("R10 sum", lane_sum(l), 0);
    rst_n = 1;
    @(posedge clk); #1;
    // R10: tables are zero; all-zero chips subtract every sample
    req = "R10"; len_m1 = 3; phase = 3; run = 1;
    run_chips(4, 0, 0);
    stop_bank();

    // R7: load both tables while stopped
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < MAXC; a++) begin
        code[s][a] = 1'($urandom_range(0, 1));
        wr(1'(s), a, code[s][a]);
      end

    // R1 R2 R3: full-length boundary, sync table
    req = "R1"; len_m1 = 7; phase = 7; csel = 0; run = 1;
    run_chips(32, 0, 0);
    stop_bank();

    // R3: boundary mid-sequence, with input gaps (R1 R2)
    req = "R3"; len_m1 = 9; phase = 4; run = 1;
    run_chips(45, 1, 0);
    stop_bank();

    // R2: one-chip sequence
    req = "R2"; len_m1 = 0; phase = 0; run = 1;
    run_chips(10, 1, 0);
    stop_bank();

    // R5: data table
    req = "R5"; csel = 1; len_m1 = 12; phase = 12; run = 1;
    run_chips(39, 0, 0);
    stop_bank();

    // R6: random lane masks
    req = "R6"; csel = 0; len_m1 = 5; phase = 2;
    for (int k = 0; k < 4; k++) begin
      en = NL'($urandom);
      run = 1;
      run_chips(18, 1, 0);
      stop_bank();
    end
    en = '0; run = 1; run_chips(6, 0, 0); stop_bank();
    en = '1;

    // R8: stop mid-symbol discards the partial sum
    req = "R8"; len_m1 = 7; phase = 7; run = 1;
    run_chips(5, 0, 0);
    stop_bank();
    run = 1;
    run_chips(16, 0, 0);
    stop_bank();

    // R7: write while running must not alter the table
    req = "R7"; run = 1;
    set_samples(0);
    wen = 1; wsel = 0; waddr = 5; wbit = ~code[0][5];
    step(1);
    wen = 0;
    run_chips(15, 0, 0);
    stop_bank();

    // R9: 1024 full-scale negative samples, all-zero chips
    req = "R9";
    for (int a = 0; a < MAXC; a++) begin code[0][a] = 0; wr(0, a, 0); end
    len_m1 = AW'(MAXC - 1); phase = AW'(MAXC - 1); run = 1;
    run_chips(MAXC, 0, 1);
    for (int l = 0; l < NL; l++)
      chk("R9 full scale", lane_sum(l), longint'(MAXC) * (1 << (SW-1)));
    stop_bank();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule